// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the timing strobes of the external memory bus of an 8-bit microcontroller core that has 16 KB of on-chip program memory. It runs on the oscillator clock and splits time into slots of six oscillator periods. At the boundary between two slots it chooses what the next slot will be:

- an internal fetch,
- an external program fetch, or
- an external data-memory cycle that replaces one fetch slot.

For each slot it drives an address-latch strobe, a program-store strobe, the multiplexed low address/data byte with its drive enable, and the high address byte.

The core supplies the program counter, the level of the external-access pin, a configuration bit that silences the address-latch strobe during on-chip execution, and a data-cycle request. Each of these inputs is sampled once per slot, on the last oscillator period of the slot before. A requester holds its request until that sampling point. It sees its cycle run in the slot that follows.

Top module: `busStrobeGen`

## Requirements
- R1: While reset is asserted, and through the first six periods after release, `ale`, `psen` and `busOe` stay 0. The first slot starts on the sixth rising clock edge after reset is released.
- R2: Every slot lasts six periods, numbered phase 0 to 5. In an external fetch slot `ale` is 1 in phases 0 and 1 only. During uninterrupted external fetching, successive rising edges of `ale` are exactly six periods apart.
- R3: `psen` is 1 only in phases 3 and 4 of an external fetch slot. It stays 0 through every internal fetch slot.
- R4: A fetch slot is external when `eaPin` is 0, or when `pc` is 16'h4000 or above. It is internal when `eaPin` is 1 and `pc` is 16'h3FFF or below. `extFetch` is 1 for exactly the external fetch slots.
- R5: In an internal fetch slot `ale` pulses in phases 0 and 1 unless `aleDisable` was 1 when the slot was chosen, in which case it stays 0. `aleDisable` has no effect on external fetch slots.
- R6: If `dataReq` is 1 when a slot is chosen, that slot is a data cycle, with `ale` and `psen` both 0 throughout. The next slot follows six periods later under the normal rules.
- R7: In external fetch and data slots, `busOe` is 1 in phases 0 to 2. `busOut` carries the low address byte there: `pc[7:0]`, or `dataAddr[7:0]` for a data cycle. In phases 3 to 5, `busOe` is 0, except in a data cycle with `dataWrite` = 1, where `busOut` carries `dataWdata`.
- R8: `addrHigh` equals `pc[15:8]` during an external fetch slot and `dataAddr[15:8]` during a data slot. Otherwise it is 0.
- R9: `busOe` is 0 throughout internal fetch slots and the idle slot after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| pc | input | 16 | Program counter of the next fetch |
| eaPin | input | 1 | External-access pin level; 1 allows internal fetches |
| aleDisable | input | 1 | Silences the latch strobe during internal fetches |
| dataReq | input | 1 | Requests an external data cycle in place of the next fetch |
| dataWrite | input | 1 | 1 = data write cycle, 0 = data read cycle |
| dataAddr | input | 16 | Data-cycle address |
| dataWdata | input | 8 | Data-cycle write byte |
| ale | output | 1 | Address-latch strobe, active high |
| psen | output | 1 | Program-store strobe, active high |
| busOut | output | 8 | Multiplexed low address / write data byte |
| busOe | output | 1 | Drive enable for `busOut` |
| addrHigh | output | 8 | High address byte |
| extFetch | output | 1 | 1 while the current slot fetches from external memory |

## Verification
A wrong slot kind shows up within one slot. `extFetch`, `addrHigh` and the `ale` pulse disagree with the expected values in phase 0 of the slot that was mis-chosen, and that is most visible at program counters on either side of 16'h4000. A phase counter that skips or stalls shifts every later strobe. This is caught on the very next `ale` or `psen` edge, and by the measured six-period spacing between latch pulses. A data cycle that is wrongly captured, or that leaks a strobe, appears as a stray pulse or as a wrong address or write byte on `busOut` within the same six periods.

// File: rtl/busStrobePkg.sv
package busStrobePkg;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_INT  = 2'd1,
    SLOT_EXT  = 2'd2,
    SLOT_DATA = 2'd3
  } slotKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // last phase: datapath loads the next slot's operands
    logic driveAddr;   // put low address byte on the bus
    logic driveWdata;  // put write byte on the bus
    logic selData;     // address source is the data-cycle address
    logic highEn;      // high address byte is meaningful
  } busCtl_t;

endpackage

// File: rtl/busStrobeCtrl.sv
module busStrobeCtrl
  import busStrobePkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int INT_SIZE = 16384,
  parameter int SLOT_LEN = 6,
  parameter int ALE_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc,
  input  logic              eaPin,
  input  logic              aleDisable,
  input  logic              dataReq,
  input  logic              dataWrite,
  output busCtl_t           ctl,
  output logic              ale,
  output logic              psen,
  output logic              extFetch
);

  localparam int PH_W = $clog2(SLOT_LEN);
  localparam logic [PH_W-1:0] PH_LAST    = PH_W'(SLOT_LEN - 1);
  localparam logic [PH_W-1:0] PH_ALE_END = PH_W'(ALE_LEN);
  localparam logic [PH_W-1:0] PH_TURN    = PH_W'(ALE_LEN + 1);
  localparam logic [ADDR_W-1:0] INT_BOUND = ADDR_W'(INT_SIZE);

  logic [PH_W-1:0] phase;
  slotKind_t       kind;
  slotKind_t       nextKind;
  logic            aleOff;
  logic            wrQ;

  // choose the kind of the coming slot from the inputs of the last phase
  always_comb begin
    if (dataReq)                          nextKind = SLOT_DATA;
    else if (!eaPin || (pc >= INT_BOUND)) nextKind = SLOT_EXT;
    else                                  nextKind = SLOT_INT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      kind   <= SLOT_IDLE;
      aleOff <= 1'b0;
      wrQ    <= 1'b0;
    end else if (phase == PH_LAST) begin
      phase  <= '0;
      kind   <= nextKind;
      aleOff <= aleDisable;
      wrQ    <= dataWrite;
    end else begin
      phase  <= phase + 1'b1;
    end
  end

  logic inAddrHalf;
  logic inAlePhase;
  logic inStorePhase;
  logic busSlot;

  always_comb begin
    inAlePhase   = phase < PH_ALE_END;
    inAddrHalf   = phase < PH_TURN;
    inStorePhase = (phase >= PH_TURN) && (phase < PH_LAST);
    busSlot      = (kind == SLOT_EXT) || (kind == SLOT_DATA);

    ale  = inAlePhase &&
           ((kind == SLOT_EXT) || ((kind == SLOT_INT) && !aleOff));
    psen = inStorePhase && (kind == SLOT_EXT);
    extFetch = (kind == SLOT_EXT);

    ctl.capture    = (phase == PH_LAST);
    ctl.driveAddr  = busSlot && inAddrHalf;
    ctl.driveWdata = (kind == SLOT_DATA) && wrQ && !inAddrHalf;
    ctl.selData    = (kind == SLOT_DATA);
    ctl.highEn     = busSlot;
  end

endmodule

// File: rtl/busStrobePath.sv
module busStrobePath
  import busStrobePkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [DATA_W-1:0] dataWdata,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [ADDR_W-DATA_W-1:0] addrHigh
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdQ;
  logic [ADDR_W-1:0] curAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ   <= '0;
      addrQ <= '0;
      wdQ   <= '0;
    end else if (ctl.capture) begin
      pcQ   <= pc;
      addrQ <= dataAddr;
      wdQ   <= dataWdata;
    end
  end

  always_comb begin
    curAddr  = ctl.selData ? addrQ : pcQ;
    busOe    = ctl.driveAddr || ctl.driveWdata;
    if (ctl.driveAddr)       busOut = curAddr[DATA_W-1:0];
    else if (ctl.driveWdata) busOut = wdQ;
    else                     busOut = '0;
    addrHigh = ctl.highEn ? curAddr[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
  end

endmodule

// File: rtl/busStrobeGen.sv
module busStrobeGen
  import busStrobePkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int INT_SIZE = 16384,
  parameter int SLOT_LEN = 6,
  parameter int ALE_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc,
  input  logic              eaPin,
  input  logic              aleDisable,
  input  logic              dataReq,
  input  logic              dataWrite,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [DATA_W-1:0] dataWdata,
  output logic              ale,
  output logic              psen,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [ADDR_W-DATA_W-1:0] addrHigh,
  output logic              extFetch
);

  busCtl_t ctl;

  busStrobeCtrl #(
    .ADDR_W  (ADDR_W),
    .INT_SIZE(INT_SIZE),
    .SLOT_LEN(SLOT_LEN),
    .ALE_LEN (ALE_LEN)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pc        (pc),
    .eaPin     (eaPin),
    .aleDisable(aleDisable),
    .dataReq   (dataReq),
    .dataWrite (dataWrite),
    .ctl       (ctl),
    .ale       (ale),
    .psen      (psen),
    .extFetch  (extFetch)
  );

  busStrobePath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .pc       (pc),
    .dataAddr (dataAddr),
    .dataWdata(dataWdata),
    .busOut   (busOut),
    .busOe    (busOe),
    .addrHigh (addrHigh)
  );

endmodule

// File: rtl/busStrobeChk.sv
module busStrobeChk #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ale,
  input logic              psen,
  input logic [DATA_W-1:0] busOut,
  input logic              busOe,
  input logic [HI_W-1:0]   addrHigh,
  input logic              extFetch
);

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!ale && !psen && !busOe)); // R1

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ale && psen)); // R2

  AST_ALE_TWO_WIDE: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale ##1 !ale); // R2

  AST_PSEN_ONLY_EXT: assert property (@(posedge clk) disable iff (rst)
    psen |-> extFetch); // R3

  AST_PSEN_BUS_FLOATS: assert property (@(posedge clk) disable iff (rst)
    psen |-> !busOe); // R7

  AST_ALE_WITH_ADDR: assert property (@(posedge clk) disable iff (rst)
    (ale && extFetch) |-> busOe); // R7

  AST_ADDR_HELD_OVER_FALL: assert property (@(posedge clk) disable iff (rst)
    ($fell(ale) && extFetch) |-> ($stable(busOut) && busOe)); // R7

  AST_HIGH_BYTE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (extFetch && $past(extFetch) && !$rose(ale)) |-> $stable(addrHigh)); // R8

endmodule

bind busStrobeGen busStrobeChk #(
  .DATA_W(DATA_W),
  .HI_W  (ADDR_W - DATA_W)
) u_busStrobeChk (
  .clk     (clk),
  .rst     (rst),
  .ale     (ale),
  .psen    (psen),
  .busOut  (busOut),
  .busOe   (busOe),
  .addrHigh(addrHigh),
  .extFetch(extFetch)
);

// File: tb/busStrobeGen_bench.sv
module busStrobeGen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 7200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pc = '0;
  logic        eaPin = 1'b1;
  logic        aleDisable = 1'b0;
  logic        dataReq = 1'b0;
  logic        dataWrite = 1'b0;
  logic [15:0] dataAddr = '0;
  logic [7:0]  dataWdata = '0;
  logic        ale;
  logic        psen;
  logic [7:0]  busOut;
  logic        busOe;
  logic [7:0]  addrHigh;
  logic        extFetch;

  always #(CLK_PERIOD/2) clk = ~clk;

  busStrobeGen u_busStrobeGen (
    .clk(clk), .rst(rst), .pc(pc), .eaPin(eaPin), .aleDisable(aleDisable),
    .dataReq(dataReq), .dataWrite(dataWrite), .dataAddr(dataAddr),
    .dataWdata(dataWdata), .ale(ale), .psen(psen), .busOut(busOut),
    .busOe(busOe), .addrHigh(addrHigh), .extFetch(extFetch)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state: 0 idle, 1 internal, 2 external, 3 data
  int          mPhase = 0;
  int          mKind  = 0;
  logic        mAleOff = 1'b0;
  logic        mWr = 1'b0;
  logic [15:0] mPc = '0;
  logic [15:0] mAddr = '0;
  logic [7:0]  mWd = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic expAle();
    return (mPhase < 2) && (mKind == 2 || (mKind == 1 && !mAleOff));
  endfunction
  function automatic logic expPsen();
    return (mKind == 2) && (mPhase == 3 || mPhase == 4);
  endfunction
  function automatic logic expOe();
    return (mKind >= 2) && ((mPhase < 3) || (mKind == 3 && mWr));
  endfunction
  function automatic logic [7:0] expBus();
    if (mPhase < 3) return (mKind == 3) ? mAddr[7:0] : mPc[7:0];
    return mWd;
  endfunction
  function automatic logic [7:0] expHigh();
    if (mKind == 2) return mPc[15:8];
    if (mKind == 3) return mAddr[15:8];
    return 8'h00;
  endfunction

  task automatic checkOutputs();
    string tA, tP, tO;
    tA = (mKind == 0) ? "R1" : (mKind == 3) ? "R6" :
         (mAleOff && mKind != 0) ? "R5" : "R2";
    tP = (mKind == 0) ? "R1" : (mKind == 3) ? "R6" : "R3";
    tO = (mKind == 0) ? "R1" : (mKind == 1) ? "R9" : "R7";
    chk(ale == expAle(), tA, "ale", 16'(ale), 16'(expAle()));
    chk(psen == expPsen(), tP, "psen", 16'(psen), 16'(expPsen()));
    chk(busOe == expOe(), tO, "busOe", 16'(busOe), 16'(expOe()));
    if (expOe())
      chk(busOut == expBus(), "R7", "busOut", 16'(busOut), 16'(expBus()));
    chk(extFetch == (mKind == 2), "R4", "extFetch", 16'(extFetch), 16'(mKind == 2));
    chk(addrHigh == expHigh(), "R8", "addrHigh", 16'(addrHigh), 16'(expHigh()));
  endtask

  task automatic advanceModel();
    if (rst) begin
      mPhase = 0; mKind = 0; mAleOff = 1'b0; mWr = 1'b0;
      mPc = '0; mAddr = '0; mWd = '0;
    end else if (mPhase == 5) begin
      mPhase = 0;
      if (dataReq)                       mKind = 3;
      else if (!eaPin || pc >= 16'h4000) mKind = 2;
      else                               mKind = 1;
      mAleOff = aleDisable; mWr = dataWrite;
      mPc = pc; mAddr = dataAddr; mWd = dataWdata;
    end else begin
      mPhase++;
    end
  endtask

  task automatic driveInputs(input int cyc);
    dataAddr  = 16'($urandom);
    dataWdata = 8'($urandom);
    dataWrite = 1'($urandom);
    if (cyc < 60) begin            // R2/R5: external only, disable bit set
      eaPin = 1'b0; aleDisable = 1'b1; dataReq = 1'b0; pc = 16'($urandom);
    end else if (cyc < 120) begin  // R4: last internal address
      eaPin = 1'b1; aleDisable = 1'b0; dataReq = 1'b0; pc = 16'h3FFF;
    end else if (cyc < 180) begin  // R4: first external address
      eaPin = 1'b1; aleDisable = 1'b0; dataReq = 1'b0; pc = 16'h4000;
    end else if (cyc < 240) begin  // R6: back-to-back data cycles
      eaPin = 1'b1; dataReq = 1'b1; pc = 16'h0100;
    end else if (cyc < 300) begin  // R5: internal code, strobe silenced
      eaPin = 1'b1; aleDisable = 1'b1; dataReq = 1'b0; pc = 16'h1234;
    end else begin
      eaPin      = ($urandom % 4) != 0;
      aleDisable = 1'($urandom);
      dataReq    = ($urandom % 5) == 0;
      if ($urandom % 2) pc = 16'h3FFE + 16'($urandom % 4);
      else              pc = 16'($urandom);
    end
    rst = (cyc >= 3000 && cyc < 3004);
  endtask

  int lastRise = -1;
  logic prevAle = 1'b0;
  int sinceRst = 0;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    advanceModel();
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(negedge clk);
      checkOutputs();
      // R1: first slot only after six edges since release
      if (!rst && sinceRst < 6)
        chk(!ale && !busOe, "R1", "quiet after release", 16'({ale, busOe}), 16'h0);
      // R2: six-period cadence of latch pulses in external-only run
      if (ale && !prevAle) begin
        if (cyc < 60 && lastRise >= 0)
          chk(cyc - lastRise == 6, "R2", "ale spacing", 16'(cyc - lastRise), 16'd6);
        lastRise = cyc;
      end
      prevAle = ale;
      driveInputs(cyc);
      sinceRst = rst ? 0 : sinceRst + 1;
      advanceModel();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule